// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

The controller gathers 32 level-sensitive interrupt sources, split into two groups of 16 (group A and group B), and drives five processor interrupt lines. A source takes part only while its input level is high and software has set its enable bit. Eighteen of the sources own a 3-bit steering field that picks one of the five lines. The other fourteen always go to line 0.

Every interrupt line is a registered OR of the active sources steered to it. For each line the block also gives, with no register delay, the index of the first contributing source in a fixed scan order, together with a flag that is high when no source contributes. A dispatcher reads that index to find the source it must service, and a high flag marks a spurious wake-up.

Software reaches the block through a synchronous 16-bit register port. Writes are taken on the clock edge and reads are combinational.

Top module: `irq_route_ctrl`

## Requirements
- R1: The pending views at address 0x00 (group A) and 0x20 (group B) read the current levels of `src_a` and `src_b` in the same cycle. Writes to these two addresses change nothing.
- R2: The enable registers at 0x0C (group A) and 0x26 (group B) are 16-bit read/write registers and reset to 0. Bit n enables pin n of its group. A source is active only when its level and its enable bit are both 1.
- R3: The steering registers sit at 0x04, 0x06, 0x1C and 0x1E (registers 0 to 3). The field for slot f occupies bits 3f+2:3f. Register 0 slots 0..4 steer A pins 0, 1, 2, 3, 8. Register 1 slots 0, 2, 3 steer A pins 9, 11, 12. Register 2 slots 0..4 steer B pins 0, 1, 3, 4, 5. Register 3 slots 0..4 steer B pins 6, 7, 8, 9, 10.
- R4: A written field value greater than 4 leaves the stored field unchanged. Valid fields in the same write still take their new values.
- R5: Steering-register bits outside any field read 0 and cannot be set. A source that has no field always goes to line 0.
- R6: After reset, A pin 2 goes to line 1, B pin 0 goes to line 2, and every other source goes to line 0. Register 0 reads 0x0040, register 2 reads 0x0002, and registers 1 and 3 read 0.
- R7: `cpu_irq[k]` goes high when at least one active source is steered to line k. It is registered, so it shows the state one clock after a change of level, enable or steering.
- R8: `first_src[5k+4:5k]` gives the lowest-index active source steered to line k. The index is pin for group A and 16 + pin for group B, so all of group A is scanned before group B. The field reads 0 when there is no such source.
- R9: `no_src[k]` is 1 exactly when no active source is steered to line k.
- R10: Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| src_a | input | 16 | Group A source levels |
| src_b | input | 16 | Group B source levels |
| cpu_irq | output | 5 | Registered processor interrupt lines |
| first_src | output | 25 | Per-line index of the first contributing source, 5 bits per line |
| no_src | output | 5 | Per-line no-contributor flag |

## Verification
Random source levels, enable values and steering writes are mixed so that several active sources often compete for one line. This separates correct scan order from wrong orders, such as one that favours group B or high pins. Steering writes mix valid and out-of-range field values in the same word, which shows whether fields are filtered one by one or whether the whole write is dropped. Directed steps cover the reset steering, writes to the pending views, and writes to unmapped addresses. Each step checks the interrupt lines both in the first cycle after a change and in the cycle after that, to confirm the one-clock lag.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int GRP_W     = 16;
    localparam int NUM_GRP   = 2;
    localparam int NUM_SRC   = GRP_W * NUM_GRP;
    localparam int NUM_OUT   = 5;
    localparam int FLD_W     = 3;
    localparam int NUM_ASG   = 4;
    localparam int FLD_PER   = 5;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;

    localparam logic [ADDR_W-1:0] ADR_PEND_A = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_ASG0   = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_ASG1   = 6'h06;
    localparam logic [ADDR_W-1:0] ADR_MASK_A = 6'h0C;
    localparam logic [ADDR_W-1:0] ADR_ASG2   = 6'h1C;
    localparam logic [ADDR_W-1:0] ADR_ASG3   = 6'h1E;
    localparam logic [ADDR_W-1:0] ADR_PEND_B = 6'h20;
    localparam logic [ADDR_W-1:0] ADR_MASK_B = 6'h26;

    // Location code: bit 5 = steerable, bits 4:3 = register, bits 2:0 = slot
    function automatic logic [5:0] loc_of(input int s);
        case (s)
            0:  return 6'b1_00_000;
            1:  return 6'b1_00_001;
            2:  return 6'b1_00_010;
            3:  return 6'b1_00_011;
            8:  return 6'b1_00_100;
            9:  return 6'b1_01_000;
            11: return 6'b1_01_010;
            12: return 6'b1_01_011;
            16: return 6'b1_10_000;
            17: return 6'b1_10_001;
            19: return 6'b1_10_010;
            20: return 6'b1_10_011;
            21: return 6'b1_10_100;
            22: return 6'b1_11_000;
            23: return 6'b1_11_001;
            24: return 6'b1_11_010;
            25: return 6'b1_11_011;
            26: return 6'b1_11_100;
            default: return 6'b0_00_000;
        endcase
    endfunction

    function automatic bit loc_ok(input int s);
        return loc_of(s)[5];
    endfunction

    function automatic int loc_reg(input int s);
        return int'(loc_of(s)[4:3]);
    endfunction

    function automatic int loc_fld(input int s);
        return int'(loc_of(s)[2:0]);
    endfunction

    function automatic bit fld_ok(input int r, input int f);
        bit hit;
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
            if (loc_ok(s) && loc_reg(s) == r && loc_fld(s) == f) hit = 1'b1;
        return hit;
    endfunction

    function automatic logic [DATA_W-1:0] fld_bits(input int r);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int f = 0; f < FLD_PER; f++)
            if (fld_ok(r, f)) m[f*FLD_W +: FLD_W] = '1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] asg_rst(input int r);
        case (r)
            0: return 16'h0040;
            2: return 16'h0002;
            default: return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [GRP_W-1:0]          pend_a,
    input  logic [GRP_W-1:0]          pend_b,
    output logic [DATA_W-1:0]         rdata,
    output logic [GRP_W-1:0]          mask_a,
    output logic [GRP_W-1:0]          mask_b,
    output logic [NUM_ASG*DATA_W-1:0] asg_flat
);
    typedef struct packed {
        logic [GRP_W-1:0]                mask_a;
        logic [GRP_W-1:0]                mask_b;
        logic [NUM_ASG-1:0][DATA_W-1:0]  asg;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_asg;
    logic [1:0] wr_r;

    always_comb begin
        wr_asg = 1'b1;
        wr_r   = 2'd0;
        case (addr)
            ADR_ASG0: wr_r = 2'd0;
            ADR_ASG1: wr_r = 2'd1;
            ADR_ASG2: wr_r = 2'd2;
            ADR_ASG3: wr_r = 2'd3;
            default:  wr_asg = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == ADR_MASK_A) st_d.mask_a = wdata;
            if (addr == ADR_MASK_B) st_d.mask_b = wdata;
            if (wr_asg) begin
                for (int f = 0; f < FLD_PER; f++) begin
                    if (fld_ok(int'(wr_r), f) && wdata[f*FLD_W +: FLD_W] <= 3'd4)
                        st_d.asg[wr_r][f*FLD_W +: FLD_W] = wdata[f*FLD_W +: FLD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask_a <= '0;
            st_q.mask_b <= '0;
            for (int r = 0; r < NUM_ASG; r++) st_q.asg[r] <= asg_rst(r);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            ADR_PEND_A: rdata = pend_a;
            ADR_PEND_B: rdata = pend_b;
            ADR_MASK_A: rdata = st_q.mask_a;
            ADR_MASK_B: rdata = st_q.mask_b;
            ADR_ASG0:   rdata = st_q.asg[0];
            ADR_ASG1:   rdata = st_q.asg[1];
            ADR_ASG2:   rdata = st_q.asg[2];
            ADR_ASG3:   rdata = st_q.asg[3];
            default:    rdata = '0;
        endcase
    end

    assign mask_a   = st_q.mask_a;
    assign mask_b   = st_q.mask_b;
    assign asg_flat = st_q.asg;

    generate
        for (genvar r = 0; r < NUM_ASG; r++) begin : g_asg_chk
            // R5
            asg_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.asg[r] & ~fld_bits(r)) == '0);
            for (genvar f = 0; f < FLD_PER; f++) begin : g_fld
                if (fld_ok(r, f)) begin : g_ok
                    // R4
                    fld_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                        st_q.asg[r][f*FLD_W +: FLD_W] <= 3'd4);
                end
            end
        end
    endgenerate

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rdata == '0 && addr != ADR_MASK_A && addr != ADR_MASK_B && !wr_asg)
        |=> $stable(st_q));
endmodule

// File: rtl/irq_route_scan.sv
module irq_route_scan
    import irq_route_pkg::*;
#(
    parameter int OUT_ID = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       active,
    input  logic [NUM_SRC*FLD_W-1:0] route,
    output logic                     hit,
    output logic [SRC_IDX_W-1:0]     first
);
    localparam logic [FLD_W-1:0] ID = FLD_W'(OUT_ID);

    always_comb begin
        hit   = 1'b0;
        first = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i] && route[i*FLD_W +: FLD_W] == ID) begin
                hit   = 1'b1;
                first = SRC_IDX_W'(i);
            end
        end
    end

    // R8
    first_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (active[first] && route[first*FLD_W +: FLD_W] == ID));
    // R8
    first_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> first == '0);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_we,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    input  logic [GRP_W-1:0]               src_a,
    input  logic [GRP_W-1:0]               src_b,
    output logic [NUM_OUT-1:0]             cpu_irq,
    output logic [NUM_OUT*SRC_IDX_W-1:0]   first_src,
    output logic [NUM_OUT-1:0]             no_src
);
    typedef struct packed {
        logic [NUM_OUT-1:0] irq;
    } out_st_t;

    logic [GRP_W-1:0]          mask_a, mask_b;
    logic [NUM_ASG*DATA_W-1:0] asg_flat;
    logic [NUM_SRC-1:0]        active;
    logic [NUM_SRC*FLD_W-1:0]  route;
    logic [NUM_OUT-1:0]        hit;
    out_st_t                   out_d, out_q;

    irq_route_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr_en    (reg_we),
        .wdata    (reg_wdata),
        .pend_a   (src_a),
        .pend_b   (src_b),
        .rdata    (reg_rdata),
        .mask_a   (mask_a),
        .mask_b   (mask_b),
        .asg_flat (asg_flat)
    );

    assign active = {src_b & mask_b, src_a & mask_a};

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
            if (loc_ok(s)) begin : g_steer
                localparam int BASE = loc_reg(s) * DATA_W + loc_fld(s) * FLD_W;
                assign route[s*FLD_W +: FLD_W] = asg_flat[BASE +: FLD_W];
            end else begin : g_fixed
                assign route[s*FLD_W +: FLD_W] = '0;
            end
        end

        for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
            irq_route_scan #(.OUT_ID(k)) u_scan (
                .clk    (clk),
                .rst_n  (rst_n),
                .active (active),
                .route  (route),
                .hit    (hit[k]),
                .first  (first_src[k*SRC_IDX_W +: SRC_IDX_W])
            );
        end
    endgenerate

    always_comb begin
        out_d     = out_q;
        out_d.irq = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cpu_irq = out_q.irq;
    assign no_src  = ~hit;

    // R7
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_irq == ~$past(no_src));
    // R2
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a == '0 && mask_b == '0) |=> cpu_irq == '0);
    // R1
    pend_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_PEND_B) |-> reg_rdata == src_b);
endmodule

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] src_a = '0, src_b = '0;
    logic [4:0]  cpu_irq;
    logic [24:0] first_src;
    logic [4:0]  no_src;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_mask_a, m_mask_b;
    int          m_route [32];

    always #2.5 clk = ~clk;

    irq_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_a(src_a), .src_b(src_b),
        .cpu_irq(cpu_irq), .first_src(first_src), .no_src(no_src)
    );

    // Steering location per R3: returns reg*8+slot, or -1 when fixed to line 0 (R5)
    function automatic int b_loc(int s);
        case (s)
            0: return 0;   1: return 1;   2: return 2;   3: return 3;   8: return 4;
            9: return 8;  11: return 10; 12: return 11;
            16: return 16; 17: return 17; 19: return 18; 20: return 19; 21: return 20;
            22: return 24; 23: return 25; 24: return 26; 25: return 27; 26: return 28;
            default: return -1;
        endcase
    endfunction

    function automatic int asg_of(logic [5:0] a);
        case (a)
            6'h04: return 0; 6'h06: return 1; 6'h1C: return 2; 6'h1E: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(logic [5:0] a);
        logic [15:0] v;
        int r;
        v = '0;
        r = asg_of(a);
        if (a == 6'h00) v = src_a;
        else if (a == 6'h20) v = src_b;
        else if (a == 6'h0C) v = m_mask_a;
        else if (a == 6'h26) v = m_mask_b;
        else if (r >= 0) begin
            for (int s = 0; s < 32; s++)
                if (b_loc(s) >= 0 && b_loc(s) / 8 == r)
                    v[(b_loc(s) % 8) * 3 +: 3] = 3'(m_route[s]);
        end
        return v;
    endfunction

    function automatic bit is_act(int s);
        return s < 16 ? (src_a[s] & m_mask_a[s]) : (src_b[s-16] & m_mask_b[s-16]);
    endfunction

    function automatic int exp_first(int k);
        for (int s = 0; s < 32; s++)
            if (is_act(s) && m_route[s] == k) return s;
        return 32;
    endfunction

    function automatic logic [4:0] exp_irq();
        logic [4:0] v;
        for (int k = 0; k < 5; k++) v[k] = exp_first(k) != 32;
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_write(logic [5:0] a, logic [15:0] d);
        int r;
        r = asg_of(a);
        if (a == 6'h0C) m_mask_a = d;
        else if (a == 6'h26) m_mask_b = d;
        else if (r >= 0) begin
            for (int s = 0; s < 32; s++)
                if (b_loc(s) >= 0 && b_loc(s) / 8 == r && d[(b_loc(s) % 8) * 3 +: 3] <= 3'd4)
                    m_route[s] = int'(d[(b_loc(s) % 8) * 3 +: 3]);
        end
    endtask

    task automatic check_regs();
        logic [5:0] adrs [9] = '{6'h00, 6'h20, 6'h0C, 6'h26, 6'h04, 6'h06, 6'h1C, 6'h1E, 6'h12};
        string      tags [9] = '{"R1", "R1", "R2", "R2", "R3 R5 R6", "R3 R5 R6", "R3 R5 R6", "R3 R5 R6", "R10"};
        for (int i = 0; i < 9; i++) begin
            reg_addr = adrs[i];
            #0.1;
            check(tags[i], reg_rdata, exp_rd(adrs[i]));
        end
    endtask

    task automatic check_scan();
        for (int k = 0; k < 5; k++) begin
            int e;
            e = exp_first(k);
            check("R8", first_src[k*5 +: 5], e == 32 ? 0 : e);
            check("R9", no_src[k], e == 32);
        end
    endtask

    task automatic step(bit we, logic [5:0] a, logic [15:0] d, logic [15:0] sa, logic [15:0] sb);
        logic [4:0] lag;
        @(negedge clk);
        src_a = sa; src_b = sb;
        reg_addr = a; reg_we = we; reg_wdata = d;
        lag = exp_irq();
        @(posedge clk);
        if (we) model_write(a, d);
        @(negedge clk);
        reg_we = 1'b0;
        check("R7", cpu_irq, lag);
        check_scan();
        check_regs();
        @(posedge clk);
        @(negedge clk);
        check("R7", cpu_irq, exp_irq());
    endtask

    function automatic logic [15:0] rnd_asg();
        logic [15:0] v;
        v = 16'($urandom);
        for (int f = 0; f < 5; f++)
            if ($urandom_range(0, 9) < 7) v[f*3 +: 3] = 3'($urandom_range(0, 4));
        return v;
    endfunction

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] alist [9] = '{6'h00, 6'h20, 6'h0C, 6'h26, 6'h04, 6'h06, 6'h1C, 6'h1E, 6'h10};
        void'($urandom(32'd4242));
        m_mask_a = '0; m_mask_b = '0;
        for (int s = 0; s < 32; s++) m_route[s] = 0;
        m_route[2] = 1; m_route[16] = 2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state: R2 enables zero, R6 default steering
        check("R7", cpu_irq, 0);
        check_scan();
        check_regs();
        // R1: writes to pending views are ignored
        step(1, 6'h00, 16'hFFFF, 16'h0000, 16'h0000);
        step(1, 6'h20, 16'hFFFF, 16'h0000, 16'h0000);
        // R10: unmapped writes have no effect
        step(1, 6'h08, 16'hFFFF, 16'h0000, 16'h0000);
        step(1, 6'h3E, 16'hFFFF, 16'h0000, 16'h0000);
        // R4: all fields 7 leaves steering unchanged
        step(1, 6'h04, 16'hFFFF, 16'h0004, 16'h0001);
        // R4: mixed valid (slot0=3) and invalid (slot1=5) fields
        step(1, 6'h04, 16'h002B, 16'h0004, 16'h0001);
        // R6/R8: enable everything, check default steering and scan order
        step(1, 6'h0C, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        step(1, 6'h26, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        // R8: group A wins over group B on the same line
        step(1, 6'h1C, 16'h0003, 16'h0002, 16'h0001);
        step(1, 6'h04, 16'h0018, 16'h0002, 16'h0001);
        // R5: fixed source (A pin 15) drives line 0
        step(0, 6'h00, 16'h0000, 16'h8000, 16'h0000);
        for (int i = 0; i < 400; i++) begin
            logic [5:0]  a;
            logic [15:0] d;
            a = alist[$urandom_range(0, 8)];
            d = asg_of(a) >= 0 ? rnd_asg() : 16'($urandom);
            step($urandom_range(0, 3) != 0, a, d, 16'($urandom) & 16'($urandom),
                 16'($urandom) & 16'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule